// File: doc/BRIEF.md
# Eight-bit ALU with compare flags

This block is the purely combinational arithmetic-logic unit of a small 8-bit processor core. A 4-bit operation code picks one of twelve functions over two operand bytes, and one result byte comes out in the same cycle. There is no clock, no reset and no state. The surrounding decode logic drives the operation code and the operands, and the write-back path takes the result.

The unit provides wrap-around addition, increment and decrement, bitwise NOT, AND and OR, and logical shifts in both directions by a variable amount. It also has a three-way unsigned compare. The compare does not set a status register. It packs its verdict into the low three bits of the result byte, so ordinary register moves can carry it.

Three immediate forms (add, AND and OR) run on the same adder and logic slices. For these, a multiplexer in front of the datapath replaces the second operand with the immediate byte. Operation codes that are not assigned produce a zero result.

Top module: `alu8_core`

## Requirements
- R1: Code 0x0 gives `a_i + b_i` modulo 256; no carry is produced.
- R2: Code 0x1 gives `a_i + 1` modulo 256 (0xFF becomes 0x00).
- R3: Code 0x2 gives `a_i - 1` modulo 256 (0x00 becomes 0xFF).
- R4: Code 0x3 compares `a_i` and `b_i` as unsigned numbers. Result bit 0 is set when they are equal, bit 1 when `a_i` is lower, bit 2 when `a_i` is higher. Bits 7 to 3 are zero, and exactly one of bits 2 to 0 is set.
- R5: Codes 0x4, 0x5 and 0x6 give `~a_i`, `a_i & b_i` and `a_i | b_i`.
- R6: Code 0x7 shifts `a_i` right logically by `b_i` places, filling with zeros.
- R7: Code 0x8 shifts `a_i` left logically by `b_i` places, filling with zeros.
- R8: For either shift, a shift amount of 8 or more gives 0x00.
- R9: Codes 0xB, 0xC and 0xD give `a_i + imm_i` (modulo 256), `a_i & imm_i` and `a_i | imm_i`. For these codes `b_i` has no effect.
- R10: Codes 0x9, 0xA, 0xE and 0xF give 0x00, whatever the operands.
- R11: For codes 0x1, 0x2 and 0x4 the result does not depend on `b_i` or `imm_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand, also the shift amount |
| imm_i | input | 8 | Immediate byte, used in place of `b_i` by the immediate forms |
| res_o | output | 8 | Result byte |

## Verification
The assertions inside the slices are checked every time an input changes. They cover these properties:
- The compare verdict is a single set flag with zeroed upper bits.
- An oversized shift amount gives a zero result.
- A decrement result is one below its operand.
- An unassigned operation code gives zero.

The actual values of additions, logic functions and shifts, and whether the immediate byte or `b_i` reaches the datapath, are only shown by the bench. The bench drives corner operands and random vectors, compares each result against its behavioural model, and swaps the unused operands to confirm they have no effect.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned OPW = 4;

  localparam logic [OPW-1:0] OP_ADD  = 4'h0;
  localparam logic [OPW-1:0] OP_INC  = 4'h1;
  localparam logic [OPW-1:0] OP_DEC  = 4'h2;
  localparam logic [OPW-1:0] OP_CMP  = 4'h3;
  localparam logic [OPW-1:0] OP_NOT  = 4'h4;
  localparam logic [OPW-1:0] OP_AND  = 4'h5;
  localparam logic [OPW-1:0] OP_OR   = 4'h6;
  localparam logic [OPW-1:0] OP_SHR  = 4'h7;
  localparam logic [OPW-1:0] OP_SHL  = 4'h8;
  localparam logic [OPW-1:0] OP_ADDI = 4'hB;
  localparam logic [OPW-1:0] OP_ANDI = 4'hC;
  localparam logic [OPW-1:0] OP_ORI  = 4'hD;

  typedef enum logic [1:0] {
    ARITH_ADD = 2'd0,
    ARITH_INC = 2'd1,
    ARITH_DEC = 2'd2
  } arith_kind_e;

  typedef enum logic [1:0] {
    LOGIC_NOT = 2'd0,
    LOGIC_AND = 2'd1,
    LOGIC_OR  = 2'd2
  } logic_kind_e;

  localparam int unsigned FLAG_EQ = 0;
  localparam int unsigned FLAG_LT = 1;
  localparam int unsigned FLAG_GT = 2;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  arith_kind_e  kind_i,
  output logic [W-1:0] y_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] addend;

  always_comb begin
    unique case (kind_i)
      ARITH_INC: addend = ONE;
      ARITH_DEC: addend = ONES;
      default:   addend = b_i;
    endcase
  end

  assign y_o = a_i + addend;

  always_comb begin
    if (kind_i == ARITH_DEC) begin
      AST_DEC_BELOW: assert (W'(y_o + ONE) == a_i) else $error("decrement mismatch"); // R3
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_kind_e  kind_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    unique case (kind_i)
      LOGIC_AND: y_o = a_i & b_i;
      LOGIC_OR:  y_o = a_i | b_i;
      default:   y_o = ~a_i;
    endcase
  end

  always_comb begin
    if (kind_i == LOGIC_NOT) begin
      AST_NOT_DISJOINT: assert ((y_o & a_i) == '0) else $error("not overlaps operand"); // R5
    end
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] amt_i,
  input  logic         left_i,
  output logic [W-1:0] y_o
);

  localparam int unsigned SHW = $clog2(W);

  logic [W-1:0] stage [SHW+1];
  logic         too_far;

  assign stage[0] = a_i;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int unsigned STEP = 1 << i;
    always_comb begin
      if (!amt_i[i])   stage[i+1] = stage[i];
      else if (left_i) stage[i+1] = stage[i] << STEP;
      else             stage[i+1] = stage[i] >> STEP;
    end
  end

  assign too_far = |amt_i[W-1:SHW];
  assign y_o     = too_far ? '0 : stage[SHW];

  always_comb begin
    if (amt_i >= W[W-1:0]) begin
      AST_SHIFT_FLUSH: assert (y_o == '0) else $error("oversized shift nonzero"); // R8
    end
  end

endmodule

// File: rtl/alu8_cmp.sv
module alu8_cmp
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  logic eq, lt, gt;

  assign eq = (a_i == b_i);
  assign lt = (a_i <  b_i);
  assign gt = !eq && !lt;

  always_comb begin
    y_o          = '0;
    y_o[FLAG_EQ] = eq;
    y_o[FLAG_LT] = lt;
    y_o[FLAG_GT] = gt;
  end

  always_comb begin
    AST_CMP_ONE_FLAG: assert ($countones(y_o) == 1) else $error("compare flags not single"); // R4
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] res_o
);

  logic          use_imm;
  logic [W-1:0]  opb;
  arith_kind_e   arith_kind;
  logic_kind_e   logic_kind;
  logic [W-1:0]  arith_y, logic_y, shift_y, cmp_y;

  assign use_imm = (op_i == OP_ADDI) || (op_i == OP_ANDI) || (op_i == OP_ORI);
  assign opb     = use_imm ? imm_i : b_i;

  always_comb begin
    unique case (op_i)
      OP_INC:  arith_kind = ARITH_INC;
      OP_DEC:  arith_kind = ARITH_DEC;
      default: arith_kind = ARITH_ADD;
    endcase
    unique case (op_i)
      OP_AND, OP_ANDI: logic_kind = LOGIC_AND;
      OP_OR,  OP_ORI:  logic_kind = LOGIC_OR;
      default:         logic_kind = LOGIC_NOT;
    endcase
  end

  alu8_arith #(.W(W)) u_arith (
    .a_i(a_i), .b_i(opb), .kind_i(arith_kind), .y_o(arith_y)
  );

  alu8_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(opb), .kind_i(logic_kind), .y_o(logic_y)
  );

  alu8_shift #(.W(W)) u_shift (
    .a_i(a_i), .amt_i(b_i), .left_i(op_i == OP_SHL), .y_o(shift_y)
  );

  alu8_cmp #(.W(W)) u_cmp (
    .a_i(a_i), .b_i(b_i), .y_o(cmp_y)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_INC, OP_DEC, OP_ADDI:         res_o = arith_y;
      OP_NOT, OP_AND, OP_OR, OP_ANDI, OP_ORI:  res_o = logic_y;
      OP_SHR, OP_SHL:                          res_o = shift_y;
      OP_CMP:                                  res_o = cmp_y;
      default:                                 res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == 4'h9 || op_i == 4'hA || op_i == 4'hE || op_i == 4'hF) begin
      AST_UNDEF_ZERO: assert (res_o == '0) else $error("undefined code nonzero"); // R10
    end
    if (op_i == OP_CMP) begin
      AST_CMP_HIGH_CLEAR: assert (res_o[W-1:3] == '0) else $error("compare upper bits set"); // R4
    end
  end

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

  logic       clk = 1'b0;
  logic [3:0] op;
  logic [7:0] a, b, imm;
  logic [7:0] res;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  alu8_core u_dut (.op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .res_o(res));

  function automatic int model(int o, int x, int y, int im);
    int r;
    case (o)
      0:  r = x + y;
      1:  r = x + 1;
      2:  r = x + 255;
      3:  r = (x == y) ? 1 : ((x < y) ? 2 : 4);
      4:  r = 255 - x;
      5:  r = x & y;
      6:  r = x | y;
      7:  r = (y >= 8) ? 0 : (x >> y);
      8:  r = (y >= 8) ? 0 : (x << y);
      11: r = x + im;
      12: r = x & im;
      13: r = x | im;
      default: r = 0;
    endcase
    return r % 256;
  endfunction

  function automatic string tag_of(int o, int y);
    case (o)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4, 5, 6: return "R5";
      7: return (y >= 8) ? "R8" : "R6";
      8: return (y >= 8) ? "R8" : "R7";
      11, 12, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input int o, input int x, input int y, input int im);
    int exp;
    @(posedge clk);
    op = 4'(o); a = 8'(x); b = 8'(y); imm = 8'(im);
    @(negedge clk);
    exp = model(o, x, y, im);
    n_checks++;
    if (int'(res) != exp) begin
      n_fails++;
      $display("FAIL %s op=%0h a=%0h b=%0h imm=%0h got=%0h exp=%0h",
               tag_of(o, y), o, x, y, im, res, exp);
    end
  endtask

  // R9 and R11: swapping unused operands must leave the result unchanged
  task automatic unused_check(input string tag, input int o, input int x);
    logic [7:0] first;
    @(posedge clk);
    op = 4'(o); a = 8'(x); b = 8'h00; imm = 8'h00;
    @(negedge clk);
    first = res;
    @(posedge clk);
    if (o >= 11) imm = 8'h00; else imm = 8'($urandom);
    b = 8'($urandom) | 8'h01;
    @(negedge clk);
    n_checks++;
    if (res != first) begin
      n_fails++;
      $display("FAIL %s op=%0h unused operand changed result got=%0h exp=%0h", tag, o, res, first);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    op = 4'h0; a = '0; b = '0; imm = '0;
    // initial state: add of zeros
    apply(0, 0, 0, 0);                        // R1
    apply(0, 200, 100, 0);                    // R1 wrap
    apply(0, 255, 1, 0);                      // R1 wrap
    apply(1, 255, 9, 0);                      // R2 wrap
    apply(1, 41, 0, 0);                       // R2
    apply(2, 0, 0, 0);                        // R3 wrap
    apply(2, 128, 0, 0);                      // R3
    apply(3, 5, 5, 0);                        // R4 equal
    apply(3, 4, 200, 0);                      // R4 less, unsigned
    apply(3, 200, 4, 0);                      // R4 greater, unsigned
    apply(3, 0, 255, 0);                      // R4
    apply(4, 8'hA5, 0, 0);                    // R5
    apply(5, 8'hF0, 8'h3C, 0);                // R5
    apply(6, 8'hF0, 8'h0C, 0);                // R5
    for (int s = 0; s < 12; s++) begin
      apply(7, 8'hB7, s, 0);                  // R6 / R8
      apply(8, 8'hB7, s, 0);                  // R7 / R8
    end
    apply(7, 8'hFF, 255, 0);                  // R8
    apply(8, 8'hFF, 128, 0);                  // R8
    apply(11, 250, 3, 10);                    // R9 wrap
    apply(12, 8'hF3, 8'h00, 8'h3F);           // R9
    apply(13, 8'h10, 8'hFF, 8'h01);           // R9
    for (int o = 9; o < 16; o++) begin
      if (o == 9 || o == 10 || o == 14 || o == 15) apply(o, 255, 255, 255); // R10
    end
    unused_check("R11", 1, 77);
    unused_check("R11", 2, 0);
    unused_check("R11", 4, 8'h5A);
    unused_check("R9", 11, 60);
    unused_check("R9", 12, 8'hFF);
    unused_check("R9", 13, 8'h11);
    for (int i = 0; i < 20000; i++) begin
      apply(int'($urandom_range(15, 0)), int'($urandom_range(255, 0)),
            (i % 4 == 0) ? int'($urandom_range(15, 0)) : int'($urandom_range(255, 0)),
            int'($urandom_range(255, 0)));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule